// File: doc/BRIEF.md
# Tooth Period Meter

This block times a square-wave tooth signal coming from a wheel speed pickup, such as an inductive or Hall-effect sensor on a toothed wheel. A fast, free-running reference clock drives a period counter. The counter restarts on each rising edge of the synchronised sensor signal, and the count reached at that edge is captured as one tooth period. Falling edges play no part in the measurement, because tooth and gap widths on real wheels are rarely equal.

Captured periods go into a small circular buffer of the most recent 2^LOG2_N samples. A running sum gains the new sample and loses the one it displaces, so the mean is the sum shifted right by LOG2_N bits. Each new mean comes with a one-cycle strobe. If no edge arrives before the counter saturates, the block reports a stall, reads out a zero average and empties its buffer. An optional output scales the mean tooth period by the teeth-per-revolution parameter to give the revolution period.

Top module: `tooth_period_meter`

## Requirements
- R1: While reset is held and after its release, before any sensor edge, `avg_period`, `rev_period`, `avg_valid` and `stalled` are all zero.
- R2: A captured period is the number of clock cycles between two successive rising edges of `sensor_in`. Where the falling edge sits between them has no effect on the value.
- R3: On each strobe, `avg_period` equals the floor of the sum of the last 2^LOG2_N captured periods divided by 2^LOG2_N.
- R4: `avg_valid` is high for exactly one cycle per update. When `sensor_in` is driven high between clock edges, the strobe is visible after the fourth following rising clock edge and is low again after the fifth.
- R5: The first rising edge after reset or after a stall only starts timing and captures nothing. No strobe appears until 2^LOG2_N periods have been captured since that point.
- R6: Between strobes `avg_period` holds its value unless a stall clears it.
- R7: If 2^CNT_W-1 clock cycles pass after a counted rising edge without another one, `stalled` goes high and `avg_period` reads zero. An edge spacing of 2^CNT_W-1 cycles is still captured normally. A spacing of 2^CNT_W cycles or more stalls and empties the buffer.
- R8: `stalled` clears at the next rising edge. That edge captures no period, and `avg_period` stays zero until the buffer has refilled.
- R9: With REV_EN set, `rev_period` equals `avg_period` multiplied by TEETH. With REV_EN clear, it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that the periods are counted in |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sensor_in | input | 1 | Raw tooth signal, asynchronous to `clk` |
| avg_period | output | CNT_W | Mean tooth period in clock cycles; zero while stalled or before the first fill |
| avg_valid | output | 1 | One-cycle strobe marking a new mean |
| stalled | output | 1 | High while the period counter is saturated (zero speed) |
| rev_period | output | CNT_W+clog2(TEETH+1) | Mean revolution period in clock cycles |

## Verification
A rising transition driven between clock edges passes through two synchroniser flops and the edge detector. It is captured at the third following clock edge, and the filter registers the new mean at the fourth. The bench therefore samples the strobe and the mean on the falling clock edge that follows the fourth rising edge, and confirms one cycle later that the strobe has dropped. A stall appears one cycle after the counter's 2^CNT_W-1st increment following a captured edge. The bench checks that `stalled` is low one sample before that point and high at it. Total strobe counts are compared with a model of the refill rules at the end.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  // Bits needed to hold the teeth-per-revolution constant.
  function automatic int unsigned teeth_width(int unsigned teeth);
    return $clog2(teeth + 1);
  endfunction

endpackage

// File: rtl/tpm_sync_edge.sv
module tpm_sync_edge (
  input  logic clk,
  input  logic rst_n_async,
  input  logic sensor_in,
  output logic rst_n_sync,
  output logic rise
);

  logic [1:0] rst_q;
  logic [2:0] smp_q;
  logic [2:0] smp_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_n_sync = rst_q[1];

  // two synchroniser stages plus one history stage for edge detection
  always_comb begin
    smp_d = {smp_q[1:0], sensor_in};
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      smp_q <= 3'b000;
    end else begin
      smp_q <= smp_d;
    end
  end

  assign rise = smp_q[1] & ~smp_q[2];

endmodule

// File: rtl/tpm_period_cnt.sv
module tpm_period_cnt #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic             cap_vld,
  output logic [CNT_W-1:0] cap_period,
  output logic             sat
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             vld_q, vld_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             per_en;

  assign sat = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (rise) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (sat) begin
      armed_d = 1'b0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    per_en = rise & armed_q & ~sat;
    vld_d  = per_en;
    per_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
    end else if (per_en) begin
      per_q <= per_d;
    end
  end

  assign cap_vld    = vld_q;
  assign cap_period = per_q;

endmodule

// File: rtl/tpm_mean_filt.sv
module tpm_mean_filt #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned LOG2_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CNT_W-1:0] din,
  input  logic             flush,
  output logic [CNT_W-1:0] mean,
  output logic             strobe
);

  localparam int unsigned N      = 1 << LOG2_N;
  localparam int unsigned SUM_W  = CNT_W + LOG2_N;
  localparam int unsigned FILL_W = LOG2_N + 1;

  logic [CNT_W-1:0]  buf_q [N];
  logic [LOG2_N-1:0] wr_q, wr_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [SUM_W-1:0]  sum_q, sum_d;
  logic [CNT_W-1:0]  mean_q, mean_d;
  logic              stb_q, stb_d;
  logic              full;
  logic [CNT_W-1:0]  oldest;
  logic              wr_en;

  assign full   = (fill_q == FILL_W'(N));
  assign oldest = full ? buf_q[wr_q] : '0;
  assign wr_en  = push & ~flush;

  always_comb begin
    wr_d   = wr_q;
    fill_d = fill_q;
    sum_d  = sum_q;
    mean_d = mean_q;
    stb_d  = 1'b0;
    if (flush) begin
      wr_d   = '0;
      fill_d = '0;
      sum_d  = '0;
      mean_d = '0;
    end else if (push) begin
      sum_d = sum_q + SUM_W'(din) - SUM_W'(oldest);
      wr_d  = wr_q + LOG2_N'(1);
      if (!full) begin
        fill_d = fill_q + FILL_W'(1);
      end
      if (fill_d == FILL_W'(N)) begin
        mean_d = sum_d[SUM_W-1:LOG2_N];
        stb_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      fill_q <= '0;
      sum_q  <= '0;
      mean_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      fill_q <= fill_d;
      sum_q  <= sum_d;
      mean_q <= mean_d;
      stb_q  <= stb_d;
    end
  end

  // sample storage: slots are read only once written, so no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      buf_q[wr_q] <= din;
    end
  end

  assign mean   = mean_q;
  assign strobe = stb_q;

endmodule

// File: rtl/tooth_period_meter.sv
module tooth_period_meter #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned LOG2_N = 3,
  parameter int unsigned TEETH  = 100,
  parameter bit          REV_EN = 1'b1,
  localparam int unsigned REV_W = CNT_W + tpm_pkg::teeth_width(TEETH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sensor_in,
  output logic [CNT_W-1:0] avg_period,
  output logic             avg_valid,
  output logic             stalled,
  output logic [REV_W-1:0] rev_period
);

  logic             rst_n_core;
  logic             rise;
  logic             cap_vld;
  logic [CNT_W-1:0] cap_period;
  logic             sat;
  logic [CNT_W-1:0] mean;
  logic             strobe;

  tpm_sync_edge u_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .sensor_in   (sensor_in),
    .rst_n_sync  (rst_n_core),
    .rise        (rise)
  );

  tpm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_core),
    .rise       (rise),
    .cap_vld    (cap_vld),
    .cap_period (cap_period),
    .sat        (sat)
  );

  tpm_mean_filt #(.CNT_W(CNT_W), .LOG2_N(LOG2_N)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n_core),
    .push   (cap_vld),
    .din    (cap_period),
    .flush  (sat),
    .mean   (mean),
    .strobe (strobe)
  );

  assign stalled    = sat;
  assign avg_valid  = strobe;
  assign avg_period = sat ? '0 : mean;

  generate
    if (REV_EN) begin : g_rev
      assign rev_period = REV_W'(avg_period) * REV_W'(TEETH);
    end else begin : g_no_rev
      assign rev_period = '0;
    end
  endgenerate

endmodule

// File: rtl/tooth_period_meter_chk.sv
module tooth_period_meter_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] avg_period,
  input logic             avg_valid,
  input logic             stalled
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |=> !avg_valid); // R4

  AST_NO_VALID_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !avg_valid); // R7

  AST_ZERO_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stalled) |-> (avg_period == '0)); // R8

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!avg_valid && !stalled && !$past(stalled)) |-> $stable(avg_period)); // R6

  AST_MEAN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> (avg_period != '0)); // R3

endmodule

bind tooth_period_meter tooth_period_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .avg_period (avg_period),
  .avg_valid  (avg_valid),
  .stalled    (stalled)
);

// File: tb/tooth_period_meter_tb.sv
module tooth_period_meter_tb;

  localparam int CW   = 8;
  localparam int LN   = 2;
  localparam int NS   = 1 << LN;
  localparam int TH   = 74;
  localparam int MAXP = (1 << CW) - 1;
  localparam int RW   = CW + 7;

  logic          clk;
  logic          rst_n;
  logic          sensor_in;
  logic [CW-1:0] avg_period;
  logic          avg_valid;
  logic          stalled;
  logic [RW-1:0] rev_period;

  int total, bad;
  int got_strobes, exp_strobes;
  int q_m [NS];
  int wr_m, fill_m, cur_mean, last_gap;
  bit armed_m;
  bit done;

  tooth_period_meter #(.CNT_W(CW), .LOG2_N(LN), .TEETH(TH), .REV_EN(1'b1)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sensor_in  (sensor_in),
    .avg_period (avg_period),
    .avg_valid  (avg_valid),
    .stalled    (stalled),
    .rev_period (rev_period)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && avg_valid) got_strobes++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // one tooth: rise now, fall after h cycles, next rise after d cycles
  task automatic tooth(input int d, input int h);
    bit expv;
    int s;
    expv = 1'b0;
    if (last_gap > MAXP) begin
      fill_m = 0; wr_m = 0; cur_mean = 0;            // R7 stall empties the filter
    end else if (armed_m) begin
      q_m[wr_m] = last_gap;                          // R2 gap between rising edges
      wr_m = (wr_m + 1) % NS;
      if (fill_m < NS) fill_m++;
      if (fill_m == NS) begin
        s = 0;
        for (int k = 0; k < NS; k++) s += q_m[k];
        cur_mean = s / NS;                           // R3 floor mean
        expv = 1'b1;
        exp_strobes++;
      end
    end
    armed_m  = 1'b1;
    last_gap = d;
    sensor_in = 1'b1;
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      if (i == 4) begin
        chk("R4/R5 strobe due", int'(avg_valid), int'(expv));
        chk("R3/R6 average", int'(avg_period), cur_mean);
        chk("R8 not stalled after edge", int'(stalled), 0);
        chk("R9 revolution period", int'(rev_period), cur_mean * TH);
      end
      if (i == 5) chk("R4 strobe width", int'(avg_valid), 0);
      if (d >= MAXP + 3 && i == MAXP + 2) chk("R7 no stall yet", int'(stalled), 0);
      if (d >= MAXP + 3 && i == MAXP + 3) begin
        chk("R7 stall flag", int'(stalled), 1);
        chk("R7 stall reads zero", int'(avg_period), 0);
      end
      if (i == h) sensor_in = 1'b0;
    end
  endtask

  initial begin
    total = 0; bad = 0; got_strobes = 0; exp_strobes = 0;
    wr_m = 0; fill_m = 0; cur_mean = 0; last_gap = 0; armed_m = 1'b0;
    for (int k = 0; k < NS; k++) q_m[k] = 0;
    done = 1'b0;
    sensor_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset avg", int'(avg_period), 0);
    chk("R1 reset valid", int'(avg_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle avg", int'(avg_period), 0);
    chk("R1 idle valid", int'(avg_valid), 0);
    chk("R1 idle stalled", int'(stalled), 0);
    chk("R1 idle rev", int'(rev_period), 0);

    tooth(20, 10);                                    // R5 first edge only arms
    for (int d = 6; d <= 40; d++) tooth(d, 1 + (d * 3) % (d - 1));
    // R2 same spacing, different duty: mean must be exact
    tooth(12, 1); tooth(12, 6); tooth(12, 11); tooth(12, 3); tooth(12, 9);
    tooth(MAXP, 100); tooth(MAXP, 3);                 // R7 largest measurable spacing
    tooth(300, 150);                                  // R7 stall inside this tooth
    tooth(10, 5);                                     // R8 restart, no capture
    for (int j = 0; j < 5; j++) tooth(9, 4);          // R5 refill
    tooth(MAXP + 1, 128);                             // R7 one past the limit
    tooth(10, 5);
    for (int j = 0; j < 6; j++) tooth(7, 2 + j % 4);
    tooth(8, 2);
    repeat (4) @(negedge clk);
    chk("R5 strobe count", got_strobes, exp_strobes);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule